// File: doc/BRIEF.md
# Separable Threshold Bilateral Luma Denoiser

This block cleans noise from a raster stream of 16-bit luma samples while keeping edges sharp. It works as a simplified bilateral filter. The spatial support is a 3×3 neighbourhood, split into two passes. The first pass looks left and right along the incoming line. The second pass looks up and down through the horizontally filtered rows, which are held in two line stores. The range kernel is a yes/no test instead of a Gaussian. A neighbour takes part in the average only when its absolute difference from the centre does not exceed a programmable threshold. The result of each pass is the rounded mean of the centre and the neighbours that passed the test.

The source delivers pixels in raster order with a valid qualifier. Three markers come with the pixels: frame start on the first pixel, line end on the last pixel of each line, and frame end together with the last line end. Filtered pixels leave in the same raster order with the same three markers. Row y of the output appears while row y+1 is arriving. After the frame end, the block emits the final row on its own, one pixel per clock. The threshold is sampled once per frame, on the frame-start pixel.

Top module: `sep_bilateral_denoise`

## Requirements
- R1: While reset is held, and on the first clock after it, outValid, outSof, outEol and outEof are 0.
- R2: A neighbour of a pass is counted when |neighbour − centre| ≤ threshold, and is left out otherwise. The boundary is inclusive: a difference equal to the threshold counts, and a threshold of 0 accepts only equal values.
- R3: Each pass always counts its centre. It outputs round-to-nearest of (sum of counted samples) / (number counted), with halves rounded up. For example, the pair {0,1} gives 1, and {0,0,1} gives 0.
- R4: The horizontal pass takes the centre at column x and the neighbours at x−1 and x+1 of the same input line. The vertical pass takes the horizontal result at (x,y) as its centre and the horizontal results at (x,y−1) and (x,y+1) as neighbours. The same threshold is used in both passes.
- R5: A tap that falls outside the frame has weight 0. This covers the left of column 0, the right of the last column, above row 0 and below the last row. Frames of a single row or a single column are therefore valid.
- R6: One output pixel is produced per input pixel, in raster order. The last row is emitted after the frame-end pixel, one per clock. The source must leave at least one idle cycle after every line-end pixel. It must also leave at least width+1 idle cycles after the frame-end pixel.
- R7: outSof marks the first output pixel of a frame, outEol the last pixel of every output line, and outEof the last pixel of the frame. outEof is always accompanied by outEol. No marker is ever high while outValid is low.
- R8: The threshold is captured on the frame-start pixel. Changes to it during the rest of the frame do not affect that frame's output.
- R9: Full-scale samples with the full-scale threshold give exact averages, with no wrap of the internal sums. All lines of a frame have the same width, from 1 to MAX_W pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input pixel qualifier |
| inPix | input | DATA_W | Input luma sample |
| inSof | input | 1 | First pixel of a frame |
| inEol | input | 1 | Last pixel of a line |
| inEof | input | 1 | Last pixel of a frame (with inEol) |
| thr | input | DATA_W | Range threshold, sampled on the frame-start pixel |
| outValid | output | 1 | Output pixel qualifier |
| outPix | output | DATA_W | Filtered luma sample |
| outSof | output | 1 | First output pixel of a frame |
| outEol | output | 1 | Last output pixel of a line |
| outEof | output | 1 | Last output pixel of a frame |

## Verification
The hardest situation to reach is the final row of a frame. It is produced by an internal flush with no input present, and it must use the stored row above, no row below, and the threshold captured at frame start. The stimulus reaches this state with frames of one row, one column and several rows, each followed by an idle stretch. Threshold inclusivity is reached with directed ramps whose steps equal the threshold, and again with the threshold one below the step. The threshold port is randomised on every pixel after frame start, so any late sampling shows up in the output values.

// File: rtl/dn_pkg.sv
package dn_pkg;
  // strobes from control to datapath; h* fields act in the input cycle,
  // v* fields are registered one cycle behind the horizontal result
  typedef struct packed {
    logic capThr;
    logic shiftIn;
    logic hFire;
    logic hLeftOk;
    logic hRightOk;
    logic vFire;
    logic vLive;
    logic vEmit;
    logic vUpOk;
    logic vDownOk;
    logic vSof;
    logic vEol;
    logic vEof;
  } ctl_t;
endpackage

// File: rtl/tap3_threshold_avg.sv
module tap3_threshold_avg #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] centre,
  input  logic [DATA_W-1:0] left,
  input  logic [DATA_W-1:0] right,
  input  logic              leftOk,
  input  logic              rightOk,
  input  logic [DATA_W-1:0] thr,
  output logic [DATA_W-1:0] avg
);
  localparam int SUM_W = DATA_W + 2;
  localparam int SH    = 2 * ((SUM_W + 3) / 2);
  localparam int PW    = SUM_W + SH + 1;
  localparam logic [PW-1:0] RECIP = PW'(((2 ** SH) + 2) / 3);

  logic [DATA_W-1:0] diffL, diffR;
  logic              takeL, takeR;
  logic [SUM_W-1:0]  sum, sumP1, half, third, res;
  logic [PW-1:0]     prod;

  always_comb begin
    diffL = (left  > centre) ? left  - centre : centre - left;
    diffR = (right > centre) ? right - centre : centre - right;
    takeL = leftOk  && (diffL <= thr);
    takeR = rightOk && (diffR <= thr);
    sum   = SUM_W'(centre)
          + (takeL ? SUM_W'(left)  : '0)
          + (takeR ? SUM_W'(right) : '0);
    sumP1 = sum + SUM_W'(1);
    half  = sumP1 >> 1;
    prod  = PW'(sumP1) * RECIP;
    third = SUM_W'(prod >> SH);
    case ({takeL, takeR})
      2'b00:   res = sum;
      2'b11:   res = third;
      default: res = half;
    endcase
    avg = DATA_W'(res);
  end
endmodule

// File: rtl/bf_control.sv
module bf_control
  import dn_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int AW    = $clog2(MAX_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSof,
  input  logic          inEol,
  input  logic          inEof,
  output ctl_t          ctl,
  output logic [AW-1:0] vCol
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          p1Ok, p2Ok, tailPend, eofPend, flushOn;
  logic [AW-1:0] hColCnt, widthReg, flushCol;
  logic [1:0]    rowNum;
  logic          hFire;
  logic          vFireR, vLiveR, vEmitR, vUpOkR, vDownOkR, vSofR, vEolR, vEofR;
  logic [AW-1:0] vColR;

  assign hFire = (inValid && p1Ok) || tailPend;

  always_comb begin
    ctl.capThr   = inValid && inSof;
    ctl.shiftIn  = inValid;
    ctl.hFire    = hFire;
    ctl.hLeftOk  = p2Ok;
    ctl.hRightOk = !tailPend;
    ctl.vFire    = vFireR;
    ctl.vLive    = vLiveR;
    ctl.vEmit    = vEmitR;
    ctl.vUpOk    = vUpOkR;
    ctl.vDownOk  = vDownOkR;
    ctl.vSof     = vSofR;
    ctl.vEol     = vEolR;
    ctl.vEof     = vEofR;
    vCol         = vColR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Ok <= 1'b0;  p2Ok <= 1'b0;  tailPend <= 1'b0;
      eofPend <= 1'b0;  flushOn <= 1'b0;
      hColCnt <= '0;  widthReg <= '0;  flushCol <= '0;  rowNum <= '0;
      vFireR <= 1'b0;  vLiveR <= 1'b0;  vEmitR <= 1'b0;  vUpOkR <= 1'b0;
      vDownOkR <= 1'b0;  vSofR <= 1'b0;  vEolR <= 1'b0;  vEofR <= 1'b0;
      vColR <= '0;
    end else begin
      vFireR <= 1'b0;
      vEmitR <= 1'b0;
      if (inValid) begin
        p2Ok <= p1Ok;
        p1Ok <= 1'b1;
        if (inEol) begin
          tailPend <= 1'b1;
          eofPend  <= inEof;
        end
        if (inSof) rowNum <= '0;
      end
      if (hFire) begin
        // live column: centre row is the previous stored row
        vFireR   <= 1'b1;
        vLiveR   <= 1'b1;
        vColR    <= hColCnt;
        vEmitR   <= (rowNum != 2'd0);
        vUpOkR   <= (rowNum == 2'd2);
        vDownOkR <= 1'b1;
        vSofR    <= (rowNum == 2'd1) && (hColCnt == '0);
        vEolR    <= tailPend;
        vEofR    <= 1'b0;
        hColCnt  <= hColCnt + ONE;
      end else if (flushOn) begin
        // final row: no row below, input is idle
        vFireR   <= 1'b1;
        vLiveR   <= 1'b0;
        vColR    <= flushCol;
        vEmitR   <= 1'b1;
        vUpOkR   <= (rowNum == 2'd2);
        vDownOkR <= 1'b0;
        vSofR    <= (rowNum == 2'd1) && (flushCol == '0);
        vEolR    <= (flushCol == widthReg);
        vEofR    <= (flushCol == widthReg);
        flushCol <= flushCol + ONE;
        if (flushCol == widthReg) flushOn <= 1'b0;
      end
      if (tailPend) begin
        p1Ok     <= 1'b0;
        p2Ok     <= 1'b0;
        tailPend <= 1'b0;
        hColCnt  <= '0;
        widthReg <= hColCnt;
        if (rowNum != 2'd2) rowNum <= rowNum + 2'd1;
        if (eofPend) begin
          flushOn  <= 1'b1;
          flushCol <= '0;
          eofPend  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
  import dn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_W  = 64,
  parameter int AW     = $clog2(MAX_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [AW-1:0]     vCol,
  input  logic [DATA_W-1:0] inPix,
  input  logic [DATA_W-1:0] thr,
  output logic              outValid,
  output logic [DATA_W-1:0] outPix,
  output logic              outSof,
  output logic              outEol,
  output logic              outEof
);
  localparam int NPASS = 2;  // 0 = horizontal, 1 = vertical

  logic [DATA_W-1:0] thrReg, p1, p2, hVal;
  logic [DATA_W-1:0] rowMid [MAX_W];
  logic [DATA_W-1:0] rowUp  [MAX_W];
  logic [DATA_W-1:0] tapCen [NPASS];
  logic [DATA_W-1:0] tapL   [NPASS];
  logic [DATA_W-1:0] tapR   [NPASS];
  logic              tapLOk [NPASS];
  logic              tapROk [NPASS];
  logic [DATA_W-1:0] tapAvg [NPASS];

  always_comb begin
    tapCen[0] = p1;           tapL[0] = p2;           tapR[0] = inPix;
    tapLOk[0] = ctl.hLeftOk;  tapROk[0] = ctl.hRightOk;
    tapCen[1] = rowMid[vCol]; tapL[1] = rowUp[vCol];  tapR[1] = hVal;
    tapLOk[1] = ctl.vUpOk;    tapROk[1] = ctl.vDownOk;
  end

  for (genvar g = 0; g < NPASS; g++) begin : g_pass
    tap3_threshold_avg #(.DATA_W(DATA_W)) u_tap (
      .centre (tapCen[g]),
      .left   (tapL[g]),
      .right  (tapR[g]),
      .leftOk (tapLOk[g]),
      .rightOk(tapROk[g]),
      .thr    (thrReg),
      .avg    (tapAvg[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrReg <= '0;  p1 <= '0;  p2 <= '0;  hVal <= '0;
    end else begin
      if (ctl.capThr)  thrReg <= thr;
      if (ctl.shiftIn) begin
        p2 <= p1;
        p1 <= inPix;
      end
      if (ctl.hFire) hVal <= tapAvg[0];
    end
  end

  // line stores of horizontally filtered rows
  always_ff @(posedge clk) begin
    if (ctl.vFire && ctl.vLive) begin
      rowUp[vCol]  <= rowMid[vCol];
      rowMid[vCol] <= hVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;  outPix <= '0;
      outSof <= 1'b0;  outEol <= 1'b0;  outEof <= 1'b0;
    end else begin
      outValid <= ctl.vFire && ctl.vEmit;
      outSof   <= ctl.vFire && ctl.vEmit && ctl.vSof;
      outEol   <= ctl.vFire && ctl.vEmit && ctl.vEol;
      outEof   <= ctl.vFire && ctl.vEmit && ctl.vEof;
      if (ctl.vFire && ctl.vEmit) outPix <= tapAvg[1];
    end
  end
endmodule

// File: rtl/sep_bilateral_denoise.sv
module sep_bilateral_denoise
  import dn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inPix,
  input  logic              inSof,
  input  logic              inEol,
  input  logic              inEof,
  input  logic [DATA_W-1:0] thr,
  output logic              outValid,
  output logic [DATA_W-1:0] outPix,
  output logic              outSof,
  output logic              outEol,
  output logic              outEof
);
  localparam int AW = $clog2(MAX_W);

  ctl_t          ctl;
  logic [AW-1:0] vCol;

  bf_control #(.MAX_W(MAX_W), .AW(AW)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof),
    .inEol(inEol), .inEof(inEof), .ctl(ctl), .vCol(vCol)
  );

  bf_datapath #(.DATA_W(DATA_W), .MAX_W(MAX_W), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vCol(vCol), .inPix(inPix), .thr(thr),
    .outValid(outValid), .outPix(outPix), .outSof(outSof),
    .outEol(outEol), .outEof(outEof)
  );
endmodule

// File: rtl/sep_bilateral_denoise_chk.sv
module sep_bilateral_denoise_chk #(
  parameter int MAX_W = 64
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inEol,
  input logic outValid,
  input logic outSof,
  input logic outEol,
  input logic outEof
);
  localparam int CW = $clog2(MAX_W) + 1;

  logic [CW-1:0] lineCnt;
  logic          wasInReset = 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) lineCnt <= '0;
    else if (outValid) lineCnt <= outEol ? '0 : lineCnt + CW'(1);
  end

  // R1: outputs quiet on the edge after a reset cycle
  always @(posedge clk) begin
    if (wasInReset)
      assert_reset_quiet_R1: assert (!outValid && !outSof && !outEol && !outEof);
    wasInReset <= !rstN;
  end

  assert_eof_with_eol_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEof |-> outEol);

  assert_markers_need_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(outSof || outEol || outEof));

  assert_sof_at_line_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSof |-> lineCnt == '0);

  assert_line_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> lineCnt < CW'(MAX_W));

  assert_idle_after_eol_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inEol |=> !inValid);
endmodule

bind sep_bilateral_denoise sep_bilateral_denoise_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEol(inEol),
  .outValid(outValid), .outSof(outSof), .outEol(outEol), .outEof(outEof)
);

// File: tb/sep_bilateral_denoise_tb.sv
`timescale 1ns/1ps
module sep_bilateral_denoise_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inPix = '0;
  logic        inSof = 1'b0, inEol = 1'b0, inEof = 1'b0;
  logic [15:0] thr = '0;
  logic        outValid;
  logic [15:0] outPix;
  logic        outSof, outEol, outEof;

  int total = 0;
  int bad = 0;
  int gotCnt = 0;
  int          img  [0:7][0:15];
  int          hMat [0:7][0:15];
  int          eMat [0:7][0:15];
  int          gotPix [0:255];
  int          gotMk  [0:255];

  always #2 clk = ~clk;

  sep_bilateral_denoise u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPix(inPix), .inSof(inSof),
    .inEol(inEol), .inEof(inEof), .thr(thr), .outValid(outValid),
    .outPix(outPix), .outSof(outSof), .outEol(outEol), .outEof(outEof)
  );

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (gotCnt < 256) begin
        gotPix[gotCnt] = int'(outPix);
        gotMk[gotCnt]  = {29'd0, outSof, outEol, outEof};
      end
      gotCnt = gotCnt + 1;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int avg3(int c, int l, int r, bit lok, bit rok, int t);
    int s = c;
    int n = 1;
    if (lok && absd(l, c) <= t) begin s += l; n++; end
    if (rok && absd(r, c) <= t) begin s += r; n++; end
    return (2 * s + n) / (2 * n);
  endfunction

  task automatic computeExp(input int w, input int hgt, input int t);
    for (int y = 0; y < hgt; y++)
      for (int x = 0; x < w; x++)
        hMat[y][x] = avg3(img[y][x], (x > 0) ? img[y][x-1] : 0,
                          (x < w-1) ? img[y][x+1] : 0, x > 0, x < w-1, t);
    for (int y = 0; y < hgt; y++)
      for (int x = 0; x < w; x++)
        eMat[y][x] = avg3(hMat[y][x], (y > 0) ? hMat[y-1][x] : 0,
                          (y < hgt-1) ? hMat[y+1][x] : 0, y > 0, y < hgt-1, t);
  endtask

  task automatic runFrame(input int w, input int hgt, input int thrA,
                          input bit wiggle, input bit gaps, input string tag);
    gotCnt = 0;
    @(negedge clk);
    thr = 16'(thrA);
    for (int y = 0; y < hgt; y++) begin
      for (int x = 0; x < w; x++) begin
        if (gaps && ($urandom % 4 == 0)) begin
          @(negedge clk);
          inValid = 1'b0; inSof = 1'b0; inEol = 1'b0; inEof = 1'b0;
        end
        @(negedge clk);
        inValid = 1'b1;
        inPix   = 16'(img[y][x]);
        inSof   = (x == 0) && (y == 0);
        inEol   = (x == w-1);
        inEof   = (x == w-1) && (y == hgt-1);
        if (wiggle && !((x == 0) && (y == 0))) thr = 16'($urandom);
      end
      @(negedge clk);
      inValid = 1'b0; inSof = 1'b0; inEol = 1'b0; inEof = 1'b0;
    end
    repeat (w + 8) @(negedge clk);
    computeExp(w, hgt, thrA);
    chk("R6 count", gotCnt == w * hgt, gotCnt, w * hgt);
    for (int y = 0; y < hgt; y++)
      for (int x = 0; x < w; x++) begin
        int idx = y * w + x;
        int mk = ((idx == 0) ? 4 : 0) + ((x == w-1) ? 2 : 0)
               + ((x == w-1 && y == hgt-1) ? 1 : 0);
        if (idx < gotCnt) begin
          chk(tag, gotPix[idx] == eMat[y][x], gotPix[idx], eMat[y][x]);
          chk("R7 markers", gotMk[idx] == mk, gotMk[idx], mk);
        end
      end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid", outValid == 1'b0, int'(outValid), 0);
    chk("R1 markers", {outSof, outEol, outEof} == 3'b0, int'({outSof, outEol, outEof}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after", outValid == 1'b0, int'(outValid), 0);

    // R3: flat field passes through; small values exercise rounding
    for (int y = 0; y < 4; y++) for (int x = 0; x < 5; x++) img[y][x] = 1000;
    runFrame(5, 4, 0, 1'b0, 1'b0, "R3 flat");
    for (int y = 0; y < 4; y++) for (int x = 0; x < 6; x++) img[y][x] = (x * 7 + y * 3) % 3 == 0 ? 0 : 1;
    runFrame(6, 4, 1, 1'b0, 1'b0, "R3 rounding");

    // R2: ramp steps equal the threshold, then threshold one below
    for (int y = 0; y < 5; y++) for (int x = 0; x < 8; x++) img[y][x] = 100 + 10 * ((x + y) % 3);
    runFrame(8, 5, 10, 1'b0, 1'b0, "R2 inclusive");
    runFrame(8, 5, 9, 1'b0, 1'b0, "R2 exclusive");
    runFrame(8, 5, 0, 1'b0, 1'b1, "R2 zero");

    // R4: random separable behaviour with input gaps
    for (int k = 0; k < 4; k++) begin
      for (int y = 0; y < 6; y++) for (int x = 0; x < 12; x++) img[y][x] = int'($urandom_range(4000, 0));
      runFrame(12, 6, int'($urandom_range(1500, 0)), 1'b0, 1'b1, "R4 random");
    end

    // R5: edge frames
    img[0][0] = 777;
    runFrame(1, 1, 65535, 1'b0, 1'b0, "R5 1x1");
    for (int y = 0; y < 5; y++) img[y][0] = 500 + 40 * y;
    runFrame(1, 5, 65535, 1'b0, 1'b1, "R5 1 col");
    for (int x = 0; x < 7; x++) img[0][x] = 300 + 25 * x;
    runFrame(7, 1, 65535, 1'b0, 1'b1, "R5 1 row");
    for (int y = 0; y < 2; y++) for (int x = 0; x < 3; x++) img[y][x] = int'($urandom_range(255, 0));
    runFrame(3, 2, 200, 1'b0, 1'b0, "R5 2 rows");

    // R8: threshold moves after frame start
    for (int y = 0; y < 4; y++) for (int x = 0; x < 6; x++) img[y][x] = int'($urandom_range(300, 0));
    runFrame(6, 4, 60, 1'b1, 1'b1, "R8 thr hold");

    // R9: full-scale samples, widest test line
    for (int y = 0; y < 3; y++) for (int x = 0; x < 16; x++) img[y][x] = 65535 - int'($urandom_range(2, 0));
    runFrame(16, 3, 65535, 1'b0, 1'b1, "R9 full scale");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule